// File: doc/BRIEF.md
# Chained Descriptor Receive DMA Engine

This block takes the byte stream coming out of a serial frame receiver and stores it in memory. It uses a linked chain of buffer descriptors that software builds in memory. Each descriptor names a data buffer and the address of the next descriptor. For each descriptor, the engine fetches it, fills its buffer with frame bytes, and writes back the byte count and a status byte. It then follows the chain pointer to the next descriptor.

Software controls the channel through a small register file. The current-descriptor register is where the engine works. The end-descriptor register marks the first descriptor the engine must not touch, and software moves it forward to hand descriptors back. A per-buffer byte limit sets how much one buffer holds, so a long frame is split across several chained descriptors. Sticky status flags, an interrupt-enable mask and a level interrupt report progress and trouble.

Descriptor layout in memory, byte offsets from the descriptor address, multi-byte fields little-endian:

| Offset | Field |
|--------|-------|
| +0, +1 | address of the next descriptor (16 bits) |
| +2 to +5 | buffer start address (32 bits) |
| +6, +7 | byte count |
| +8 | status byte |

Top module: `chain_rx_dma`

## Requirements
- R1: After reset, every register reads 0 (current descriptor, end descriptor, buffer limit, status, interrupt enable, frame count), `irq` is low, `rx_ready` is low and no memory access is issued.
- R2: While running, the bytes of a frame are written in arrival order to buffer start + 0, +1, and so on. The byte count at descriptor +6/+7 equals the number of bytes placed in that buffer.
- R3: No more than the buffer limit (register 2) is written into one buffer. A longer frame continues in the next chained descriptor, and the descriptor that holds the earlier part gets a status byte of 0x00.
- R4: The descriptor that holds a frame's last byte gets a status byte with bit 7 set (end of message). Bits 4..0 copy `rx_err` as sampled with the last byte: bit 4 overrun, bit 3 short frame, bit 2 abort, bit 1 residual bits, bit 0 CRC error.
- R5: Before it fetches a descriptor, the engine compares the current and end descriptor registers. If they are equal, it clears the run bit, sets the end-of-transfer flag and fetches nothing. The rest of a frame cut off this way is discarded.
- R6: A descriptor's byte count (+6, then +7) is written in the two cycles just before its status byte (+8).
- R7: While the channel is not running, arriving frames are accepted and discarded with no memory write, and the buffer-overflow flag is set.
- R8: Writing bit 0 of the command register (4'h5) clears the run bit at once and sends the engine to idle. The partly filled descriptor gets no count and no status.
- R9: The status register (address 3) holds the run bit [7] and the flags end-of-transfer [0], end-of-message [1], buffer-overflow [2] and counter-overflow [3]. A status write sets the run bit to wdata[7]. Flags whose wdata bit is 1 are cleared only if wdata[6] is also 1.
- R10: `irq` is high exactly while some status flag is set whose bit is also set in the interrupt-enable register (address 4, bits 3..0).
- R11: The frame counter (address 6) counts descriptors that end a frame, and the end-of-message flag is set for each one. When the counter wraps from all ones to zero, the counter-overflow flag is set. Command bit 1 clears the counter.
- R12: After a descriptor's status byte is written, the current-descriptor register takes that descriptor's next-descriptor address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 3 | register select: 0 current, 1 end, 2 buffer limit, 3 status, 4 irq enable, 5 command, 6 frame count |
| reg_wdata | input | 16 | register write data |
| reg_rdata | output | 16 | read data for `reg_addr`, combinational |
| rx_valid | input | 1 | receive byte present |
| rx_data | input | 8 | receive byte |
| rx_last | input | 1 | byte is the last of its frame |
| rx_err | input | 5 | frame error flags, valid with `rx_last` |
| rx_ready | output | 1 | engine takes the byte on this edge |
| mem_en | output | 1 | memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | byte address |
| mem_wdata | output | 8 | write byte |
| mem_rdata | input | 8 | read byte, valid the cycle after the read |
| irq | output | 1 | level interrupt |

## Verification
The hardest state to reach from the ports is a frame that is cut off in the middle. This happens when the frame crosses a buffer boundary into a descriptor that turns out to be the end descriptor, or when software aborts while the engine is filling a buffer. The bench builds a four-entry ring whose end pointer sits two descriptors ahead. It sets a small buffer limit so that one twelve-byte frame spans both free descriptors and stops right at the end. A separate scenario aborts after part of a frame has been taken, then sends the remainder to confirm that it is discarded.

// File: rtl/crd_pkg.sv
package crd_pkg;
  localparam int DP_W        = 16;  // descriptor pointer width
  localparam int BP_W        = 32;  // buffer pointer / memory address width
  localparam int LN_W        = 16;  // byte count width
  localparam int ERR_W       = 5;   // receiver error flags
  localparam int FETCH_BYTES = 6;   // chain + buffer pointer bytes
  localparam int SH_W        = 8 * FETCH_BYTES;
  localparam int OFS_LEN     = 6;
  localparam int OFS_STAT    = 8;
  localparam int NFLAG       = 4;

  localparam logic [2:0] RA_CUR  = 3'd0;
  localparam logic [2:0] RA_END  = 3'd1;
  localparam logic [2:0] RA_BFL  = 3'd2;
  localparam logic [2:0] RA_STAT = 3'd3;
  localparam logic [2:0] RA_IE   = 3'd4;
  localparam logic [2:0] RA_CMD  = 3'd5;
  localparam logic [2:0] RA_FCNT = 3'd6;

  localparam int SB_WCLR = 6;
  localparam int SB_RUN  = 7;
  localparam int DS_EOM  = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_FETCH, S_FILL, S_WLEN0, S_WLEN1, S_WSTAT, S_DROP
  } seq_state_t;
endpackage

// File: rtl/crd_fcnt.sv
module crd_fcnt #(
  parameter int FCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic              clr,
  output logic [FCNT_W-1:0] count,
  output logic              wrap_evt
);
  logic [FCNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)             cnt_d = '0;
    else if (frame_done) cnt_d = cnt_q + FCNT_W'(1);
  end

  assign wrap_evt = frame_done && !clr && (&cnt_q);
  assign count    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/crd_regs.sv
module crd_regs
  import crd_pkg::*;
#(
  parameter int FCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              cda_set,
  input  logic [DP_W-1:0]   cda_val,
  input  logic              halt_evt,
  input  logic              eom_evt,
  input  logic              drop_evt,
  input  logic              cof_evt,
  input  logic [FCNT_W-1:0] fcnt,
  output logic [DP_W-1:0]   cda,
  output logic [DP_W-1:0]   eda,
  output logic [LN_W-1:0]   bfl,
  output logic              run,
  output logic              abort_p,
  output logic              fclr_p,
  output logic [NFLAG-1:0]  flags,
  output logic [NFLAG-1:0]  ie,
  output logic              irq
);
  logic [DP_W-1:0]  cda_q, cda_d, eda_q, eda_d;
  logic [LN_W-1:0]  bfl_q, bfl_d;
  logic [NFLAG-1:0] flg_q, flg_d, ie_q, ie_d, clr_v, set_v;
  logic             run_q, run_d;
  logic             wr_cur, wr_end, wr_bfl, wr_stat, wr_ie, wr_cmd;

  assign wr_cur  = reg_wr && (reg_addr == RA_CUR);
  assign wr_end  = reg_wr && (reg_addr == RA_END);
  assign wr_bfl  = reg_wr && (reg_addr == RA_BFL);
  assign wr_stat = reg_wr && (reg_addr == RA_STAT);
  assign wr_ie   = reg_wr && (reg_addr == RA_IE);
  assign wr_cmd  = reg_wr && (reg_addr == RA_CMD);

  assign abort_p = wr_cmd && reg_wdata[0];
  assign fclr_p  = wr_cmd && reg_wdata[1];

  always_comb begin
    cda_d = cda_q;
    if (cda_set)     cda_d = cda_val;
    else if (wr_cur) cda_d = reg_wdata[DP_W-1:0];
    eda_d = wr_end ? reg_wdata[DP_W-1:0] : eda_q;
    bfl_d = wr_bfl ? reg_wdata[LN_W-1:0] : bfl_q;
    ie_d  = wr_ie  ? reg_wdata[NFLAG-1:0] : ie_q;
    clr_v = (wr_stat && reg_wdata[SB_WCLR]) ? reg_wdata[NFLAG-1:0] : '0;
    set_v = {cof_evt, drop_evt, eom_evt, halt_evt};
    flg_d = (flg_q & ~clr_v) | set_v;
    run_d = run_q;
    if (halt_evt || abort_p) run_d = 1'b0;
    if (wr_stat)             run_d = reg_wdata[SB_RUN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cda_q <= '0;
      eda_q <= '0;
      bfl_q <= '0;
      ie_q  <= '0;
      flg_q <= '0;
      run_q <= 1'b0;
    end else begin
      cda_q <= cda_d;
      eda_q <= eda_d;
      bfl_q <= bfl_d;
      ie_q  <= ie_d;
      flg_q <= flg_d;
      run_q <= run_d;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CUR:  reg_rdata = cda_q;
      RA_END:  reg_rdata = eda_q;
      RA_BFL:  reg_rdata = bfl_q;
      RA_STAT: reg_rdata = {8'h00, run_q, 3'b000, flg_q};
      RA_IE:   reg_rdata = {12'h000, ie_q};
      RA_FCNT: reg_rdata = {{(16-FCNT_W){1'b0}}, fcnt};
      default: reg_rdata = '0;
    endcase
  end

  assign cda   = cda_q;
  assign eda   = eda_q;
  assign bfl   = bfl_q;
  assign run   = run_q;
  assign flags = flg_q;
  assign ie    = ie_q;
  assign irq   = |(flg_q & ie_q);
endmodule

// File: rtl/crd_seq.sv
module crd_seq
  import crd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             abort_p,
  input  logic [DP_W-1:0]  cda,
  input  logic [DP_W-1:0]  eda,
  input  logic [LN_W-1:0]  bfl,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  input  logic [ERR_W-1:0] rx_err,
  output logic             rx_ready,
  output logic             mem_en,
  output logic             mem_we,
  output logic [BP_W-1:0]  mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  output logic             cda_set,
  output logic [DP_W-1:0]  cda_val,
  output logic             halt_evt,
  output logic             eom_evt,
  output logic             drop_evt,
  output logic [LN_W-1:0]  frag_cnt
);
  seq_state_t       st_q, st_d;
  logic [2:0]       k_q, k_d;
  logic [SH_W-1:0]  sh_q, sh_d;
  logic [LN_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic [ERR_W-1:0] err_q, err_d;
  logic             eom_q, eom_d;
  logic [BP_W-1:0]  desc_base, bufp;
  logic [DP_W-1:0]  chain;

  assign desc_base = {{(BP_W-DP_W){1'b0}}, cda};
  assign chain     = sh_q[DP_W-1:0];
  assign bufp      = sh_q[DP_W +: BP_W];
  assign cnt_inc   = cnt_q + LN_W'(1);

  always_comb begin
    st_d      = st_q;
    k_d       = k_q;
    sh_d      = sh_q;
    cnt_d     = cnt_q;
    err_d     = err_q;
    eom_d     = eom_q;
    rx_ready  = 1'b0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    cda_set   = 1'b0;
    halt_evt  = 1'b0;
    eom_evt   = 1'b0;
    drop_evt  = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (run) st_d = S_CHECK;
        else if (rx_valid) begin
          st_d     = S_DROP;
          drop_evt = 1'b1;
        end
      end
      S_CHECK: begin
        if (!run) st_d = S_IDLE;
        else if (cda == eda) begin
          halt_evt = 1'b1;
          st_d     = S_IDLE;
        end else begin
          st_d  = S_FETCH;
          k_d   = '0;
          cnt_d = '0;
        end
      end
      S_FETCH: begin
        if (k_q != 3'd0) sh_d = {mem_rdata, sh_q[SH_W-1:8]};
        if (k_q < 3'(FETCH_BYTES)) begin
          mem_en   = 1'b1;
          mem_addr = desc_base + BP_W'(k_q);
          k_d      = k_q + 3'd1;
        end else begin
          st_d = S_FILL;
        end
      end
      S_FILL: begin
        rx_ready = 1'b1;
        if (rx_valid) begin
          mem_en    = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = bufp + BP_W'(cnt_q);
          mem_wdata = rx_data;
          cnt_d     = cnt_inc;
          if (rx_last) begin
            err_d = rx_err;
            eom_d = 1'b1;
            st_d  = S_WLEN0;
          end else if (cnt_inc == bfl) begin
            err_d = '0;
            eom_d = 1'b0;
            st_d  = S_WLEN0;
          end
        end
      end
      S_WLEN0: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_base + BP_W'(OFS_LEN);
        mem_wdata = cnt_q[7:0];
        st_d      = S_WLEN1;
      end
      S_WLEN1: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_base + BP_W'(OFS_LEN + 1);
        mem_wdata = cnt_q[15:8];
        st_d      = S_WSTAT;
      end
      S_WSTAT: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_base + BP_W'(OFS_STAT);
        mem_wdata = {eom_q, 2'b00, err_q};
        cda_set   = 1'b1;
        eom_evt   = eom_q;
        st_d      = S_CHECK;
      end
      S_DROP: begin
        rx_ready = 1'b1;
        if (rx_valid && rx_last) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
    if (abort_p) st_d = S_IDLE;
  end

  assign cda_val  = chain;
  assign frag_cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      k_q   <= '0;
      sh_q  <= '0;
      cnt_q <= '0;
      err_q <= '0;
      eom_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      k_q   <= k_d;
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
      eom_q <= eom_d;
    end
  end
endmodule

// File: rtl/chain_rx_dma.sv
module chain_rx_dma
  import crd_pkg::*;
#(
  parameter int FCNT_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  input  logic [4:0]  rx_err,
  output logic        rx_ready,
  output logic        mem_en,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        irq
);
  logic [1:0]        rst_pipe;
  logic              rst_n_s;
  logic [DP_W-1:0]   cda, eda, cda_val;
  logic [LN_W-1:0]   bfl, frag_cnt;
  logic              run, abort_p, fclr_p, cda_set;
  logic              halt_evt, eom_evt, drop_evt, cof_evt;
  logic [NFLAG-1:0]  flags, ie;
  logic [FCNT_W-1:0] fcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  crd_regs #(.FCNT_W(FCNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cda_set(cda_set), .cda_val(cda_val),
    .halt_evt(halt_evt), .eom_evt(eom_evt), .drop_evt(drop_evt), .cof_evt(cof_evt),
    .fcnt(fcnt), .cda(cda), .eda(eda), .bfl(bfl), .run(run),
    .abort_p(abort_p), .fclr_p(fclr_p), .flags(flags), .ie(ie), .irq(irq)
  );

  crd_seq u_seq (
    .clk(clk), .rst_n(rst_n_s), .run(run), .abort_p(abort_p),
    .cda(cda), .eda(eda), .bfl(bfl),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
    .rx_ready(rx_ready),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cda_set(cda_set), .cda_val(cda_val),
    .halt_evt(halt_evt), .eom_evt(eom_evt), .drop_evt(drop_evt),
    .frag_cnt(frag_cnt)
  );

  crd_fcnt #(.FCNT_W(FCNT_W)) u_fcnt (
    .clk(clk), .rst_n(rst_n_s), .frame_done(eom_evt), .clr(fclr_p),
    .count(fcnt), .wrap_evt(cof_evt)
  );
endmodule

// File: rtl/crd_checker.sv
module crd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        halt_evt,
  input logic        abort_p,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [15:0] cda,
  input logic [15:0] bfl,
  input logic [15:0] frag_cnt,
  input logic        mem_en,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        rx_ready,
  input logic [3:0]  flags,
  input logic        irq
);
  logic [31:0] base;
  assign base = {16'h0000, cda};

  p_len_before_stat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && mem_addr == base + 32'd8)
      |-> $past(mem_en && mem_we && mem_addr == base + 32'd7));

  p_halt_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_evt && !(reg_wr && reg_addr == 3'd3)) |=> !run);

  p_abort_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_p |=> !run);

  p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && mem_en && mem_we) |-> (frag_cnt < bfl));

  p_no_read_while_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !(mem_en && !mem_we));

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != 4'h0));
endmodule

bind chain_rx_dma crd_checker u_chk (
  .clk(clk), .rst_n(rst_n_s), .run(run), .halt_evt(halt_evt), .abort_p(abort_p),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .cda(cda), .bfl(bfl), .frag_cnt(frag_cnt),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .rx_ready(rx_ready),
  .flags(flags), .irq(irq)
);

// File: tb/chain_rx_dma_bench.sv
`timescale 1ns/1ps
module chain_rx_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        rx_valid, rx_last, rx_ready;
  logic [7:0]  rx_data;
  logic [4:0]  rx_err;
  logic        mem_en, mem_we, irq;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        tb_we;
  logic [9:0]  tb_addr;
  logic [7:0]  tb_data;
  logic [7:0]  mem [0:1023];
  int          vectors = 0;
  int          fails = 0;
  int          cyc = 0;

  always #2.5 clk = ~clk;

  chain_rx_dma u_chain_rx_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
    .rx_ready(rx_ready), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_data;
    else if (mem_en && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    else if (mem_en) mem_rdata <= mem[mem_addr[9:0]];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [9:0] a, input logic [7:0] d);
    tb_we = 1'b1; tb_addr = a; tb_data = d;
    @(posedge clk); @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic put_desc(input logic [9:0] a, input logic [15:0] nxt, input logic [31:0] buf_a);
    poke(a, nxt[7:0]);       poke(a + 10'd1, nxt[15:8]);
    poke(a + 10'd2, buf_a[7:0]);  poke(a + 10'd3, buf_a[15:8]);
    poke(a + 10'd4, buf_a[23:16]); poke(a + 10'd5, buf_a[31:24]);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send(input logic [7:0] d, input logic last, input logic [4:0] e);
    rx_valid = 1'b1; rx_data = d; rx_last = last; rx_err = e;
    while (!rx_ready) begin @(posedge clk); @(negedge clk); end
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = '0;
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R1 register reset", v, 0);
    end
    chk("R1 irq reset", irq, 0);
    chk("R1 rx_ready reset", rx_ready, 0);
    chk("R1 no memory access", mem_en, 0);
  endtask

  task automatic t_single();
    logic [15:0] v;
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0030); wr(3'd2, 16'd16); wr(3'd4, 16'h0000);
    wr(3'd3, 16'h0080);
    send(8'h11, 0, 0); send(8'h22, 0, 0); send(8'h33, 0, 0);
    send(8'h44, 0, 0); send(8'h55, 1, 0);
    settle();
    chk("R2 first byte", mem[10'h100], 8'h11);
    chk("R2 last byte", mem[10'h104], 8'h55);
    chk("R2 length low", mem[10'h006], 8'd5);
    chk("R2 length high", mem[10'h007], 8'd0);
    chk("R4 status clean frame", mem[10'h008], 8'h80);
    rd(3'd0, v); chk("R12 advanced to chain", v, 16'h0010);
    rd(3'd3, v); chk("R11 eom flag and run", v, 16'h0082);
    rd(3'd6, v); chk("R11 frame count 1", v, 1);
    chk("R10 irq masked", irq, 0);
  endtask

  task automatic t_spill();
    logic [15:0] v;
    wr(3'd2, 16'd8); wr(3'd4, 16'h0001);
    for (int i = 0; i < 12; i++) send(8'hA0 + 8'(i), (i == 11), (i == 11) ? 5'b00001 : 5'b0);
    settle();
    chk("R3 fragment byte 7", mem[10'h147], 8'hA7);
    chk("R3 fragment length", mem[10'h016], 8'd8);
    chk("R3 fragment status", mem[10'h018], 8'h00);
    chk("R3 tail byte", mem[10'h183], 8'hAB);
    chk("R2 tail length", mem[10'h026], 8'd4);
    chk("R4 tail status crc", mem[10'h028], 8'h81);
    rd(3'd3, v); chk("R5 halted with eot", v, 16'h0003);
    rd(3'd0, v); chk("R5 stops at end", v, 16'h0030);
    chk("R5 end descriptor untouched", mem[10'h038], 8'hEE);
    chk("R10 irq on eot", irq, 1);
    rd(3'd6, v); chk("R11 frame count 2", v, 2);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    wr(3'd3, 16'h000F);
    rd(3'd3, v); chk("R9 no clear without enable", v, 16'h0003);
    wr(3'd3, 16'h0041);
    rd(3'd3, v); chk("R9 clear eot only", v, 16'h0002);
    chk("R10 irq drops", irq, 0);
    wr(3'd4, 16'h0002);
    chk("R10 irq on eom enable", irq, 1);
    wr(3'd3, 16'h004F);
    rd(3'd3, v); chk("R9 clear all", v, 0);
    chk("R10 irq off", irq, 0);
  endtask

  task automatic t_drop();
    logic [15:0] v;
    send(8'h01, 0, 0); send(8'h02, 0, 0); send(8'h03, 1, 0);
    settle();
    rd(3'd3, v); chk("R7 overflow flag", v, 16'h0004);
    chk("R7 no write", mem[10'h1C0], 8'hEE);
    rd(3'd0, v); chk("R7 pointer kept", v, 16'h0030);
    rd(3'd6, v); chk("R7 count kept", v, 2);
    wr(3'd3, 16'h004F);
  endtask

  task automatic t_abort();
    logic [15:0] v;
    wr(3'd1, 16'h0010); wr(3'd2, 16'd16); wr(3'd3, 16'h0080);
    send(8'h61, 0, 0); send(8'h62, 0, 0); send(8'h63, 0, 0);
    wr(3'd5, 16'h0001);
    rd(3'd3, v); chk("R8 run cleared", v, 0);
    send(8'h64, 0, 0); send(8'h65, 1, 0);
    settle();
    rd(3'd3, v); chk("R8 remainder dropped", v, 16'h0004);
    chk("R8 partial byte stored", mem[10'h1C2], 8'h63);
    chk("R8 no length", mem[10'h036], 8'hEE);
    chk("R8 no status", mem[10'h038], 8'hEE);
    rd(3'd0, v); chk("R8 pointer kept", v, 16'h0030);
    wr(3'd3, 16'h004F);
  endtask

  task automatic t_count();
    logic [15:0] v;
    put_desc(10'h040, 16'h0040, 32'h0000_0200);
    wr(3'd5, 16'h0002);
    rd(3'd6, v); chk("R11 counter cleared", v, 0);
    wr(3'd0, 16'h0040); wr(3'd1, 16'h0000); wr(3'd3, 16'h0080);
    for (int i = 0; i < 15; i++) send(8'(i), 1, 0);
    settle();
    rd(3'd6, v); chk("R11 count 15", v, 15);
    rd(3'd3, v); chk("R11 no wrap yet", v, 16'h0082);
    send(8'h5A, 1, 0);
    settle();
    rd(3'd6, v); chk("R11 wrapped", v, 0);
    rd(3'd3, v); chk("R11 counter overflow", v, 16'h008A);
    chk("R2 reused buffer", mem[10'h200], 8'h5A);
    chk("R2 one byte length", mem[10'h046], 8'd1);
    chk("R12 self chain", mem[10'h048], 8'h80);
    wr(3'd3, 16'h004F);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    rx_valid = 0; rx_data = 0; rx_last = 0; rx_err = 0;
    tb_we = 0; tb_addr = 0; tb_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    for (int a = 0; a < 1024; a++) poke(10'(a), 8'hEE);
    put_desc(10'h000, 16'h0010, 32'h0000_0100);
    put_desc(10'h010, 16'h0020, 32'h0000_0140);
    put_desc(10'h020, 16'h0030, 32'h0000_0180);
    put_desc(10'h030, 16'h0000, 32'h0000_01C0);
    t_single();
    t_spill();
    t_clear();
    t_drop();
    t_abort();
    t_count();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule